// File: doc/BRIEF.md
# SATA Link Power Sub-State Manager

This block sits on the host side of a SATA port and keeps track of the PHY power sub-state while the port is in its normal operating power state. The link is always in one of four visible conditions: fully up (PHY logic and PLL running), a light low-power state, a deeper low-power state, or down because the port is disabled. The block is receive-only. It never asks for a low-power state on its own. It enters the light or deep state only when the device sends a decoded request strobe, and it acknowledges every such request with a one-cycle pulse.

When the transport layer raises a transfer request while the link sleeps, the block holds the transfer, drives a wake request toward the out-of-band signalling logic and waits for the PHY to report ready. The transfer is granted in the same cycle the link is back up. Each low-power state has its own wake-time limit in clock cycles. If the PHY does not come ready inside that limit, the block pulses a timeout flag and falls back to the state it was leaving, so a pending transfer then retries the wake. A deep-power input restricts the legal sleep state to the deeper one. Dropping port enable forces the link down from any state.

Internal states: `ST_READY`, `ST_PARTIAL`, `ST_SLUMBER`, `ST_WAKE_P` (waking from the light state), `ST_WAKE_S` (waking from the deep state) and `ST_OFF`. The transitions are:

- READY→SLUMBER on a deep request, or on a light request while deep mode is on.
- READY→PARTIAL on a light request.
- PARTIAL→WAKE_P on a transfer.
- PARTIAL→SLUMBER on deep mode or on a deep request.
- SLUMBER→WAKE_S on a transfer.
- WAKE_x→READY on PHY ready.
- WAKE_x→PARTIAL/SLUMBER on timeout.
- any→OFF on disable.
- OFF→READY on enable with PHY ready.

Top module: `link_pm_mgr`

## Requirements
- R1: After reset the state code is 11 (OFF) and `link_up` is 0. The state code is 00 READY, 01 light state (also while waking from it), 10 deep state (also while waking from it), 11 OFF, and `link_up` is 1 only in READY.
- R2: A light request strobe sampled while the port is enabled gives `ack_light` high in the next cycle only. In READY it moves the state to 01 at that same edge.
- R3: A deep request strobe sampled while the port is enabled gives `ack_deep` high in the next cycle only. It moves READY or the light state to 10 at that same edge. A deep request takes priority when both strobes arrive together.
- R4: The state never moves from READY to a low-power state without a device request strobe at that edge.
- R5: A transfer request in a low-power state starts a wake, and `wake_req` is high from the next cycle. The state becomes READY only at an edge where `phy_ready` is sampled high during a wake, so `wake_req` is high for at least one cycle before READY.
- R6: `xfer_grant` equals `xfer_req` while the state is READY (including the first READY cycle) and is 0 otherwise.
- R7: A wake from the light state that sees no `phy_ready` for PARTIAL_EXIT_CYC cycles returns to the light state and pulses `wake_timeout` for one cycle.
- R8: A wake from the deep state uses the separate limit SLUMBER_EXIT_CYC, with the same return and pulse.
- R9: With `deep_pwr` high, a light request is acknowledged but enters the deep state. The light state with `deep_pwr` high and no transfer pending moves to the deep state.
- R10: `port_en` low sampled at an edge forces OFF from any state, and `wake_req` drops with it.
- R11: From OFF the state becomes READY at the first edge with `port_en` and `phy_ready` both high.
- R12: A request strobe arriving during a wake is acknowledged but leaves the wake and its timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable |
| deep_pwr | input | 1 | Host or device is in a deeper power state |
| req_light | input | 1 | Decoded device request for the light low-power state |
| req_deep | input | 1 | Decoded device request for the deep low-power state |
| phy_ready | input | 1 | PHY reports the link is ready |
| xfer_req | input | 1 | Transport layer needs the link (held until granted) |
| ack_light | output | 1 | One-cycle acknowledge of a light request |
| ack_deep | output | 1 | One-cycle acknowledge of a deep request |
| wake_req | output | 1 | Request to send the wake out-of-band signal |
| state_code | output | 2 | Link state code |
| link_up | output | 1 | Link is in READY |
| xfer_grant | output | 1 | Transfer granted this cycle |
| wake_timeout | output | 1 | One-cycle flag: a wake exceeded its limit |

## Verification
Every registered result (the state code, `link_up`, `wake_req`, both acknowledges and the timeout pulse) is due one cycle after the input edge that causes it. `xfer_grant` is due in the same cycle as the READY state it depends on. The bench changes its inputs shortly after each rising edge. A behavioural model updates at the same rising edge, and all outputs are compared at the falling edge, so each compare sees exactly one edge of effect. The timeout cases are counted out in whole cycles against the two short limits the bench sets.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_READY   = 3'd0,
        ST_PARTIAL = 3'd1,
        ST_SLUMBER = 3'd2,
        ST_WAKE_P  = 3'd3,
        ST_WAKE_S  = 3'd4,
        ST_OFF     = 3'd5
    } lpm_state_e;

    localparam logic [1:0] CODE_READY = 2'b00;
    localparam logic [1:0] CODE_LIGHT = 2'b01;
    localparam logic [1:0] CODE_DEEP  = 2'b10;
    localparam logic [1:0] CODE_OFF   = 2'b11;

    localparam int N_REQ_KINDS = 2;

    function automatic logic [1:0] code_of(lpm_state_e s);
        logic [1:0] c;
        unique case (s)
            ST_READY:             c = CODE_READY;
            ST_PARTIAL, ST_WAKE_P: c = CODE_LIGHT;
            ST_SLUMBER, ST_WAKE_S: c = CODE_DEEP;
            default:              c = CODE_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_ack_gen.sv
module lpm_ack_gen #(
    parameter int KINDS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [KINDS-1:0] req,
    output logic [KINDS-1:0] ack
);
    for (genvar k = 0; k < KINDS; k++) begin : g_ack
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ack[k] <= 1'b0;
            end else begin
                ack[k] <= req[k] & port_en;
            end
        end

        AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            ack[k] |-> $past(req[k]) && $past(port_en)); // R2
    end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int PART_CYC = 1000,
    parameter int SLUM_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_deep,
    output logic expired
);
    localparam int MAX_CYC = (PART_CYC > SLUM_CYC) ? PART_CYC : SLUM_CYC;
    localparam int W       = $clog2(MAX_CYC + 1);
    localparam logic [W-1:0] PART_LAST = W'(PART_CYC - 1);
    localparam logic [W-1:0] SLUM_LAST = W'(SLUM_CYC - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] last;

    if (PART_CYC == SLUM_CYC) begin : g_shared_limit
        assign last = PART_LAST;
    end else begin : g_split_limit
        assign last = sel_deep ? SLUM_LAST : PART_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == last);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= last); // R7
endmodule

// File: rtl/lpm_state_fsm.sv
module lpm_state_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_en,
    input  logic       deep_pwr,
    input  logic       req_light,
    input  logic       req_deep,
    input  logic       phy_ready,
    input  logic       xfer_req,
    input  logic       tmr_expired,
    output logic       tmr_run,
    output logic       tmr_sel_deep,
    output logic       wake_req,
    output logic [1:0] state_code,
    output logic       link_up,
    output logic       xfer_grant,
    output logic       wake_timeout
);
    lpm_state_e st, st_nx;
    logic       to_nx;

    always_comb begin
        st_nx = st;
        to_nx = 1'b0;
        if (!port_en) begin
            st_nx = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF: begin
                    if (phy_ready) st_nx = ST_READY;
                end
                ST_READY: begin
                    if (req_deep)       st_nx = ST_SLUMBER;
                    else if (req_light) st_nx = deep_pwr ? ST_SLUMBER : ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (xfer_req)                  st_nx = ST_WAKE_P;
                    else if (deep_pwr || req_deep) st_nx = ST_SLUMBER;
                end
                ST_SLUMBER: begin
                    if (xfer_req) st_nx = ST_WAKE_S;
                end
                ST_WAKE_P: begin
                    if (phy_ready) begin
                        st_nx = ST_READY;
                    end else if (tmr_expired) begin
                        st_nx = ST_PARTIAL;
                        to_nx = 1'b1;
                    end
                end
                ST_WAKE_S: begin
                    if (phy_ready) begin
                        st_nx = ST_READY;
                    end else if (tmr_expired) begin
                        st_nx = ST_SLUMBER;
                        to_nx = 1'b1;
                    end
                end
                default: st_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st           <= ST_OFF;
            wake_timeout <= 1'b0;
        end else begin
            st           <= st_nx;
            wake_timeout <= to_nx;
        end
    end

    always_comb begin
        tmr_run      = 1'b0;
        tmr_sel_deep = 1'b0;
        wake_req     = 1'b0;
        link_up      = 1'b0;
        unique case (st)
            ST_READY:  link_up = 1'b1;
            ST_WAKE_P: begin
                tmr_run  = 1'b1;
                wake_req = 1'b1;
            end
            ST_WAKE_S: begin
                tmr_run      = 1'b1;
                tmr_sel_deep = 1'b1;
                wake_req     = 1'b1;
            end
            default: ;
        endcase
        state_code = code_of(st);
        xfer_grant = xfer_req && link_up;
    end

    AST_NO_HOST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARTIAL && $past(st) == ST_READY) |-> $past(req_light)); // R4
    AST_WAKE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && $past(st) != ST_READY && $past(st) != ST_OFF)
            |-> $past(wake_req) && $past(phy_ready)); // R5
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(port_en) |-> (st == ST_OFF) && !wake_req); // R10
    AST_DEEP_NO_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARTIAL && $past(st) == ST_READY) |-> !$past(deep_pwr)); // R9
    AST_TIMEOUT_FROM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_timeout |-> ($past(st) == ST_WAKE_P || $past(st) == ST_WAKE_S)); // R7
endmodule

// File: rtl/link_pm_mgr.sv
module link_pm_mgr #(
    parameter int PARTIAL_EXIT_CYC = 1000,
    parameter int SLUMBER_EXIT_CYC = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_en,
    input  logic       deep_pwr,
    input  logic       req_light,
    input  logic       req_deep,
    input  logic       phy_ready,
    input  logic       xfer_req,
    output logic       ack_light,
    output logic       ack_deep,
    output logic       wake_req,
    output logic [1:0] state_code,
    output logic       link_up,
    output logic       xfer_grant,
    output logic       wake_timeout
);
    import lpm_pkg::*;

    logic                   tmr_run;
    logic                   tmr_sel_deep;
    logic                   tmr_expired;
    logic [N_REQ_KINDS-1:0] req_vec;
    logic [N_REQ_KINDS-1:0] ack_vec;

    assign req_vec   = {req_deep, req_light};
    assign ack_light = ack_vec[0];
    assign ack_deep  = ack_vec[1];

    lpm_ack_gen #(.KINDS(N_REQ_KINDS)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .req     (req_vec),
        .ack     (ack_vec)
    );

    lpm_wake_timer #(
        .PART_CYC (PARTIAL_EXIT_CYC),
        .SLUM_CYC (SLUMBER_EXIT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .sel_deep (tmr_sel_deep),
        .expired  (tmr_expired)
    );

    lpm_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_en      (port_en),
        .deep_pwr     (deep_pwr),
        .req_light    (req_light),
        .req_deep     (req_deep),
        .phy_ready    (phy_ready),
        .xfer_req     (xfer_req),
        .tmr_expired  (tmr_expired),
        .tmr_run      (tmr_run),
        .tmr_sel_deep (tmr_sel_deep),
        .wake_req     (wake_req),
        .state_code   (state_code),
        .link_up      (link_up),
        .xfer_grant   (xfer_grant),
        .wake_timeout (wake_timeout)
    );

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_grant |-> xfer_req && state_code == 2'b00); // R6
endmodule

// File: tb/link_pm_mgr_test.sv
module link_pm_mgr_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_LIM = 6;
    localparam int S_LIM = 15;
    localparam int M_RDY = 0, M_PART = 1, M_SLUM = 2, M_WP = 3, M_WS = 4, M_OFF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, deep_pwr = 1'b0, req_light = 1'b0, req_deep = 1'b0;
    logic phy_ready = 1'b0, xfer_req = 1'b0;
    logic ack_light, ack_deep, wake_req, link_up, xfer_grant, wake_timeout;
    logic [1:0] state_code;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string phase = "R1";

    int m_st = M_OFF, m_cnt = 0;
    logic m_ackl = 0, m_ackd = 0, m_to = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_pm_mgr #(.PARTIAL_EXIT_CYC(P_LIM), .SLUMBER_EXIT_CYC(S_LIM)) uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .deep_pwr(deep_pwr),
        .req_light(req_light), .req_deep(req_deep), .phy_ready(phy_ready),
        .xfer_req(xfer_req), .ack_light(ack_light), .ack_deep(ack_deep),
        .wake_req(wake_req), .state_code(state_code), .link_up(link_up),
        .xfer_grant(xfer_grant), .wake_timeout(wake_timeout)
    );

    // Behavioural reference model of the requirements
    always @(posedge clk) begin
        if (rst_n) begin
            m_ackl = req_light && port_en;
            m_ackd = req_deep && port_en;
            m_to = 1'b0;
            if (!port_en) m_st = M_OFF;
            else if (m_st == M_OFF) begin
                if (phy_ready) m_st = M_RDY;
            end else if (m_st == M_RDY) begin
                if (req_deep) m_st = M_SLUM;
                else if (req_light) m_st = deep_pwr ? M_SLUM : M_PART;
            end else if (m_st == M_PART) begin
                if (xfer_req) begin m_st = M_WP; m_cnt = 0; end
                else if (deep_pwr || req_deep) m_st = M_SLUM;
            end else if (m_st == M_SLUM) begin
                if (xfer_req) begin m_st = M_WS; m_cnt = 0; end
            end else begin
                if (phy_ready) m_st = M_RDY;
                else if (m_cnt == ((m_st == M_WP) ? P_LIM : S_LIM) - 1) begin
                    m_st = (m_st == M_WP) ? M_PART : M_SLUM;
                    m_to = 1'b1;
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    function automatic int code_m(int s);
        if (s == M_RDY) return 0;
        if (s == M_PART || s == M_WP) return 1;
        if (s == M_SLUM || s == M_WS) return 2;
        return 3;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at cycle %0d: actual %0d expected %0d",
                     tag, phase, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R1 state_code", int'(state_code), code_m(m_st));
            chk("R1 link_up", int'(link_up), int'(m_st == M_RDY));
            chk("R2 ack_light", int'(ack_light), int'(m_ackl));
            chk("R3 ack_deep", int'(ack_deep), int'(m_ackd));
            chk("R5 wake_req", int'(wake_req), int'(m_st == M_WP || m_st == M_WS));
            chk("R6 xfer_grant", int'(xfer_grant), int'(xfer_req && m_st == M_RDY));
            chk("R7/R8 wake_timeout", int'(wake_timeout), int'(m_to));
        end
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic pulse_light(); req_light = 1; tick(1); req_light = 0; endtask
    task automatic pulse_deep();  req_deep = 1;  tick(1); req_deep = 0;  endtask

    initial begin
        tick(3);
        rst_n = 1;
        phase = "R1"; tick(2);                     // reset state OFF
        phase = "R11"; port_en = 1; tick(2);       // enabled, PHY not ready: stays OFF
        phy_ready = 1; tick(2);                    // OFF -> READY
        phase = "R4"; tick(4);                     // no request: stays READY
        phase = "R2"; pulse_light(); phy_ready = 0; tick(3);
        phase = "R5"; xfer_req = 1; tick(3);       // waking from light state
        phy_ready = 1; tick(1);                    // READY, grant
        phase = "R6"; tick(1); xfer_req = 0; tick(2);
        phase = "R3"; pulse_deep(); phy_ready = 0; tick(2);
        phase = "R8"; xfer_req = 1; tick(S_LIM + 4); // timeout then retry
        phy_ready = 1; tick(2); xfer_req = 0; tick(1);
        phase = "R7"; pulse_light(); phy_ready = 0; tick(1);
        xfer_req = 1; tick(P_LIM + 3);
        phase = "R12"; pulse_deep(); pulse_light(); tick(1);
        phy_ready = 1; tick(2); xfer_req = 0; tick(1);
        phase = "R3"; req_light = 1; req_deep = 1; tick(1);
        req_light = 0; req_deep = 0; tick(2);
        xfer_req = 1; tick(2); xfer_req = 0; tick(2);
        phase = "R9"; deep_pwr = 1; pulse_light(); tick(2);
        xfer_req = 1; tick(2); xfer_req = 0; tick(1);
        deep_pwr = 0; pulse_light(); tick(2);
        deep_pwr = 1; tick(2); deep_pwr = 0;
        phase = "R10"; phy_ready = 0; xfer_req = 1; tick(3);
        port_en = 0; tick(3); xfer_req = 0;
        phase = "R11"; port_en = 1; tick(2); phy_ready = 1; tick(2);
        phase = "R10"; pulse_deep(); port_en = 0; pulse_light(); tick(2);
        port_en = 1; tick(2);
        phase = "mixed";
        for (int i = 0; i < 600; i++) begin
            req_light = ($urandom_range(0, 7) == 0);
            req_deep  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 5) == 0) xfer_req = ~xfer_req;
            if ($urandom_range(0, 4) == 0) phy_ready = ~phy_ready;
            if ($urandom_range(0, 30) == 0) deep_pwr = ~deep_pwr;
            port_en = ($urandom_range(0, 60) != 0);
            tick(1);
        end
        req_light = 0; req_deep = 0; tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule